// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins that software controls through a memory-mapped register bus. Each pin has its own registers. Through them software can turn on the pin driver and set the level it drives. It can also read the pin's level after synchronisation and set up an interrupt detector for the pin. The detector senses either one edge or a level, and software chooses which polarity counts as active.

Two separate per-pin bits control what a trigger does. One of them lets the trigger latch into a status bit that software can read. The other lets the trigger raise an interrupt request. Each pin also has a routing code, and a pin's request reaches the single summary interrupt output only when that code selects the processor. Every bus access finishes in the cycle it is presented. A write takes effect at that clock edge and read data is valid in the same cycle, so the bus has no back-pressure and needs no valid/ready handshake.

Top module: `gpio_irq_bank`

## Requirements
- R1: Pin i has four 32-bit registers at byte address 0x1000 + 16*i: control at +0x0, data at +0x4, detector setup at +0x8 and status at +0xC. Its routing register is at 0x400 + 4*i. Reads from any other address, or from a pin index at or above NUM_PINS, return 0.
- R2: Bit 0 of the data register returns the pin input after a two-flop synchroniser. A change at the input therefore reads back after two clock edges and not after one. Bit 1 stores the output level and reads back as written.
- R3: Bit 9 of the control register enables the driver and appears on `pin_oe`. `pin_out` carries the stored output level while the driver is enabled and is 0 while it is disabled. Both outputs change only at a bus write.
- R4: The detector setup register holds four bits and reads back all other bits as 0. Bit 0 enables the interrupt request. Bit 1 sets polarity: 1 means a rising edge or high level, 0 means a falling edge or low level. Bit 2 selects edge sensing when 1 and level sensing when 0. Bit 3 enables status latching.
- R5: In edge mode only a transition in the chosen direction triggers. A transition in the opposite direction is ignored.
- R6: In level mode every cycle of the active level triggers again. A status clear issued while the level is still active therefore leaves the status bit set.
- R7: While bit 3 of the detector setup is 0, triggers never set the status bit. A trigger still raises the summary interrupt if bit 0 is 1. For an edge this lasts one cycle.
- R8: While bit 0 of the detector setup is 0, triggers can latch status but never raise the summary interrupt.
- R9: Writing 1 to status bit 0 clears the latched status and writing 0 leaves it unchanged. A trigger at the same edge as a clear wins, so the status stays set.
- R10: Only routing code 4 lets a pin reach the summary output. Code 7 is the reset value and keeps the pin off the output. The routing register holds 3 bits.
- R11: `irq_summary` is registered. It is high in the cycle after any routed pin with its interrupt enabled has a latched status bit or a live trigger. It falls one cycle after the last such condition ends.
- R12: After reset all pin registers are 0 except routing, which is 7. The driver is off and `irq_summary` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Levels driven on the pins |
| pin_oe | output | NUM_PINS | Driver enable for each pin |
| irq_summary | output | 1 | Combined interrupt of all routed pins |

## Verification
The bench aims a status clear at exactly the edge on which a new edge trigger lands. A design that let the clear win would lose that interrupt. It clears a level-mode pin while the level is still active, where a design with edge-only latching would report the line as idle. It switches status latching off with the interrupt enabled and then does the reverse, which catches a design that ties the two enables together. It also holds a pending pin at routing code 7 and then moves it to code 4, which exposes a summary that ignores routing. Reading the input one edge too early exposes a synchroniser that is missing a stage. A falling edge presented in rising mode exposes a detector that reacts to both edges.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned PIN_BASE     = 32'h1000;
  localparam int unsigned PIN_STRIDE   = 16;
  localparam int unsigned ROUTE_BASE   = 32'h0400;
  localparam int unsigned ROUTE_STRIDE = 4;

  localparam int unsigned CTL_OE_BIT  = 9;
  localparam int unsigned DAT_IN_BIT  = 0;
  localparam int unsigned DAT_OUT_BIT = 1;
  localparam int unsigned STAT_BIT    = 0;

  localparam int unsigned ROUTE_W   = 3;
  localparam logic [ROUTE_W-1:0] ROUTE_CPU  = 3'd4;
  localparam logic [ROUTE_W-1:0] ROUTE_NONE = 3'd7;

  // packed MSB first: raw_en is bit 3, irq_en is bit 0
  typedef struct packed {
    logic raw_en;
    logic edge_mode;
    logic pol;
    logic irq_en;
  } det_cfg_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTL,
    SEL_DAT,
    SEL_DET,
    SEL_STAT,
    SEL_ROUTE
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 16,
  localparam int unsigned IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  pin_idx
);
  localparam int unsigned PIN_SHIFT   = $clog2(PIN_STRIDE);
  localparam int unsigned ROUTE_SHIFT = $clog2(ROUTE_STRIDE);
  localparam logic [ADDR_W-1:0] PIN_LO     = ADDR_W'(PIN_BASE);
  localparam logic [ADDR_W-1:0] ROUTE_LO   = ADDR_W'(ROUTE_BASE);
  localparam logic [ADDR_W-1:0] PIN_SPAN   = ADDR_W'(NUM_PINS * PIN_STRIDE);
  localparam logic [ADDR_W-1:0] ROUTE_SPAN = ADDR_W'(NUM_PINS * ROUTE_STRIDE);

  logic [ADDR_W-1:0] pin_ofs;
  logic [ADDR_W-1:0] route_ofs;

  // subtracting the base folds "below base" into a large unsigned value
  always_comb begin
    pin_ofs   = addr - PIN_LO;
    route_ofs = addr - ROUTE_LO;
    sel       = SEL_NONE;
    pin_idx   = '0;
    if (pin_ofs < PIN_SPAN && pin_ofs[1:0] == 2'b00) begin
      pin_idx = pin_ofs[PIN_SHIFT +: IDX_W];
      unique case (pin_ofs[3:2])
        2'd0: sel = SEL_CTL;
        2'd1: sel = SEL_DAT;
        2'd2: sel = SEL_DET;
        default: sel = SEL_STAT;
      endcase
    end else if (route_ofs < ROUTE_SPAN && route_ofs[1:0] == 2'b00) begin
      pin_idx = route_ofs[ROUTE_SHIFT +: IDX_W];
      sel     = SEL_ROUTE;
    end
  end
endmodule

// File: rtl/gpio_pin_unit.sv
module gpio_pin_unit
  import gpio_bank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctl,
  input  logic               wr_dat,
  input  logic               wr_det,
  input  logic               wr_stat,
  input  logic               wr_route,
  input  logic               oe_d,
  input  logic               out_d,
  input  det_cfg_t           det_d,
  input  logic               clr_d,
  input  logic [ROUTE_W-1:0] route_d,
  input  logic               pin_s,
  output logic               oe_q,
  output logic               out_q,
  output det_cfg_t           det_q,
  output logic [ROUTE_W-1:0] route_q,
  output logic               stat_q,
  output logic               irq_req,
  output logic               routed
);
  logic prev_q;
  logic edge_hit;
  logic trig;

  always_comb begin
    edge_hit = det_q.pol ? (pin_s & ~prev_q) : (~pin_s & prev_q);
    trig     = det_q.edge_mode ? edge_hit : (pin_s == det_q.pol);
    irq_req  = det_q.irq_en & (stat_q | trig);
    routed   = (route_q == ROUTE_CPU);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
      det_q   <= '0;
      route_q <= ROUTE_NONE;
      stat_q  <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (wr_ctl)   oe_q    <= oe_d;
      if (wr_dat)   out_q   <= out_d;
      if (wr_det)   det_q   <= det_d;
      if (wr_route) route_q <= route_d;
      // a trigger outranks a clear at the same edge
      if (trig && det_q.raw_en)    stat_q <= 1'b1;
      else if (wr_stat && clr_d)   stat_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_summary
);
  localparam int unsigned IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  reg_sel_e             sel;
  logic [IDX_W-1:0]     pin_idx;
  logic [NUM_PINS-1:0]  in_s;
  logic [NUM_PINS-1:0]  oe_v, out_v, stat_v, req_v, routed_v;
  logic [NUM_PINS-1:0]  raw_en_v, irq_en_v;
  det_cfg_t             det_a   [NUM_PINS];
  logic [ROUTE_W-1:0]   route_a [NUM_PINS];
  logic                 wr_any;
  logic                 unused_wdata_bits;

  assign wr_any            = bus_en & bus_we;
  assign unused_wdata_bits = ^{bus_wdata[REG_W-1:CTL_OE_BIT+1], bus_wdata[CTL_OE_BIT-1:4]};

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (in_s)
  );

  gpio_addr_dec #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .sel     (sel),
    .pin_idx (pin_idx)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic hit;
    assign hit = wr_any && (pin_idx == IDX_W'(i));

    gpio_pin_unit u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctl   (hit && sel == SEL_CTL),
      .wr_dat   (hit && sel == SEL_DAT),
      .wr_det   (hit && sel == SEL_DET),
      .wr_stat  (hit && sel == SEL_STAT),
      .wr_route (hit && sel == SEL_ROUTE),
      .oe_d     (bus_wdata[CTL_OE_BIT]),
      .out_d    (bus_wdata[DAT_OUT_BIT]),
      .det_d    (det_cfg_t'(bus_wdata[3:0])),
      .clr_d    (bus_wdata[STAT_BIT]),
      .route_d  (bus_wdata[ROUTE_W-1:0]),
      .pin_s    (in_s[i]),
      .oe_q     (oe_v[i]),
      .out_q    (out_v[i]),
      .det_q    (det_a[i]),
      .route_q  (route_a[i]),
      .stat_q   (stat_v[i]),
      .irq_req  (req_v[i]),
      .routed   (routed_v[i])
    );

    assign raw_en_v[i] = det_a[i].raw_en;
    assign irq_en_v[i] = det_a[i].irq_en;
  end

  assign pin_oe  = oe_v;
  assign pin_out = oe_v & out_v;

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      unique case (sel)
        SEL_CTL:   bus_rdata[CTL_OE_BIT] = oe_v[pin_idx];
        SEL_DAT: begin
          bus_rdata[DAT_IN_BIT]  = in_s[pin_idx];
          bus_rdata[DAT_OUT_BIT] = out_v[pin_idx];
        end
        SEL_DET:   bus_rdata[3:0] = det_a[pin_idx];
        SEL_STAT:  bus_rdata[STAT_BIT] = stat_v[pin_idx];
        SEL_ROUTE: bus_rdata[ROUTE_W-1:0] = route_a[pin_idx];
        default:   bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_summary <= 1'b0;
    else        irq_summary <= |(req_v & routed_v);
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int unsigned NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_en,
  input logic                bus_we,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq_summary,
  input logic [NUM_PINS-1:0] stat_v,
  input logic [NUM_PINS-1:0] raw_en_v,
  input logic [NUM_PINS-1:0] irq_en_v,
  input logic [NUM_PINS-1:0] routed_v
);
  p_status_needs_rawen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_v & ~$past(stat_v) & ~$past(raw_en_v)) == '0));

  p_status_clear_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~stat_v & $past(stat_v))) |-> $past(bus_en && bus_we));

  p_pins_hold_without_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_en && bus_we) |-> ($stable(pin_out) && $stable(pin_oe)));

  p_summary_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_summary |-> $past(|(irq_en_v & routed_v)));

  p_summary_needs_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(routed_v) == '0) |-> !irq_summary);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_en      (bus_en),
  .bus_we      (bus_we),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .irq_summary (irq_summary),
  .stat_v      (stat_v),
  .raw_en_v    (raw_en_v),
  .irq_en_v    (irq_en_v),
  .routed_v    (routed_v)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic        irq_summary;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(NP), .ADDR_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_summary(irq_summary)
  );

  function automatic logic [15:0] a_ctl(int p);   return 16'h1000 + 16'(p * 16);      endfunction
  function automatic logic [15:0] a_dat(int p);   return 16'h1004 + 16'(p * 16);      endfunction
  function automatic logic [15:0] a_det(int p);   return 16'h1008 + 16'(p * 16);      endfunction
  function automatic logic [15:0] a_stat(int p);  return 16'h100C + 16'(p * 16);      endfunction
  function automatic logic [15:0] a_route(int p); return 16'h0400 + 16'(p * 4);       endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic bus_write(logic [15:0] a, logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [15:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic ticks(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(a_ctl(0), d);   chk("R12 ctl reset", d, 0);
    bus_read(a_det(0), d);   chk("R12 det reset", d, 0);
    bus_read(a_stat(0), d);  chk("R12 stat reset", d, 0);
    bus_read(a_route(3), d); chk("R10 route reset 7", d, 7);
    chk("R12 oe reset", 32'(pin_oe), 0);
    chk("R12 irq reset", 32'(irq_summary), 0);
  endtask

  task automatic t_map_and_setup();
    logic [31:0] d;
    bus_read(a_ctl(NP), d);  chk("R1 pin beyond range", d, 0);
    bus_read(16'h0000, d);   chk("R1 unmapped", d, 0);
    bus_write(a_det(1), 32'hFFFF_FFFF);
    bus_read(a_det(1), d);   chk("R4 det mask", d, 32'hF);
    bus_write(a_det(1), 0);
    bus_write(a_route(2), 32'hFFFF_FFFC);
    bus_read(a_route(2), d); chk("R10 route width", d, 4);
    bus_write(a_route(2), 7);
  endtask

  task automatic t_output();
    logic [31:0] d;
    bus_write(a_dat(1), 32'h2);
    chk("R3 out hidden when oe off", 32'(pin_out[1]), 0);
    bus_write(a_ctl(1), 32'h200);
    chk("R3 oe on", 32'(pin_oe[1]), 1);
    chk("R3 out driven", 32'(pin_out[1]), 1);
    bus_read(a_dat(1), d);  chk("R2 out readback", d & 32'h2, 32'h2);
    bus_read(a_ctl(1), d);  chk("R3 ctl readback", d, 32'h200);
    bus_write(a_ctl(1), 0);
    chk("R3 out gated again", 32'(pin_out[1]), 0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    pin_in[2] = 1'b1;
    ticks(1);
    bus_read(a_dat(2), d);  chk("R2 input not yet", d & 1, 0);
    ticks(1);
    bus_read(a_dat(2), d);  chk("R2 input after two edges", d & 1, 1);
    pin_in[2] = 1'b0;
    ticks(3);
  endtask

  task automatic t_edge_rise();
    logic [31:0] d;
    bus_write(a_route(0), 4);
    bus_write(a_det(0), 32'hF);
    pin_in[0] = 1'b1;
    ticks(2);
    chk("R11 irq one cycle after trigger", 32'(irq_summary), 0);
    ticks(1);
    chk("R11 irq raised", 32'(irq_summary), 1);
    bus_read(a_stat(0), d); chk("R5 rising latched", d, 1);
    bus_write(a_stat(0), 0);
    bus_read(a_stat(0), d); chk("R9 write 0 keeps", d, 1);
    bus_write(a_stat(0), 1);
    bus_read(a_stat(0), d); chk("R9 write 1 clears", d, 0);
    ticks(1);
    chk("R11 irq drops after clear", 32'(irq_summary), 0);
    pin_in[0] = 1'b0;
    ticks(4);
    bus_read(a_stat(0), d); chk("R5 falling ignored", d, 0);
    chk("R5 no irq on falling", 32'(irq_summary), 0);
  endtask

  task automatic t_clear_race();
    logic [31:0] d;
    pin_in[0] = 1'b1; ticks(3);
    pin_in[0] = 1'b0; ticks(3);
    pin_in[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_write(a_stat(0), 1);
    bus_read(a_stat(0), d); chk("R9 trigger beats clear", d, 1);
    bus_write(a_stat(0), 1);
    bus_read(a_stat(0), d); chk("R9 later clear works", d, 0);
    pin_in[0] = 1'b0; ticks(3);
  endtask

  task automatic t_edge_fall();
    logic [31:0] d;
    bus_write(a_route(3), 4);
    bus_write(a_det(3), 32'hD);
    pin_in[3] = 1'b1; ticks(4);
    bus_read(a_stat(3), d); chk("R5 rising ignored in falling mode", d, 0);
    pin_in[3] = 1'b0; ticks(3);
    bus_read(a_stat(3), d); chk("R5 falling latched", d, 1);
    chk("R11 irq on falling", 32'(irq_summary), 1);
    bus_write(a_stat(3), 1); ticks(1);
    chk("R11 irq clear pin3", 32'(irq_summary), 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    bus_write(a_route(4), 4);
    bus_write(a_det(4), 32'hB);
    pin_in[4] = 1'b1; ticks(3);
    bus_read(a_stat(4), d); chk("R6 level latched", d, 1);
    chk("R6 level irq", 32'(irq_summary), 1);
    bus_write(a_stat(4), 1);
    bus_read(a_stat(4), d); chk("R6 clear while active has no effect", d, 1);
    pin_in[4] = 1'b0; ticks(2);
    bus_write(a_stat(4), 1); ticks(1);
    bus_read(a_stat(4), d); chk("R6 clear after level gone", d, 0);
    chk("R6 irq gone", 32'(irq_summary), 0);
  endtask

  task automatic t_raw_off();
    logic [31:0] d;
    bus_write(a_route(5), 4);
    bus_write(a_det(5), 32'h7);
    pin_in[5] = 1'b1; ticks(3);
    chk("R7 irq without status", 32'(irq_summary), 1);
    bus_read(a_stat(5), d); chk("R7 status stays 0", d, 0);
    ticks(1);
    chk("R7 edge irq is one cycle", 32'(irq_summary), 0);
    pin_in[5] = 1'b0; ticks(3);
  endtask

  task automatic t_irq_off();
    logic [31:0] d;
    bus_write(a_route(6), 4);
    bus_write(a_det(6), 32'hE);
    pin_in[6] = 1'b1; ticks(3);
    bus_read(a_stat(6), d); chk("R8 status latches", d, 1);
    chk("R8 no irq", 32'(irq_summary), 0);
    bus_write(a_stat(6), 1);
    pin_in[6] = 1'b0; ticks(3);
  endtask

  task automatic t_route();
    logic [31:0] d;
    bus_write(a_det(7), 32'hF);
    pin_in[7] = 1'b1; ticks(3);
    bus_read(a_stat(7), d); chk("R10 status set unrouted", d, 1);
    chk("R10 code 7 blocks irq", 32'(irq_summary), 0);
    bus_write(a_route(7), 4);
    ticks(1);
    chk("R10 code 4 passes irq", 32'(irq_summary), 1);
    bus_write(a_route(7), 7);
    ticks(1);
    chk("R10 back to 7 blocks", 32'(irq_summary), 0);
    bus_write(a_stat(7), 1);
    pin_in[7] = 1'b0; ticks(3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map_and_setup();
    t_output();
    t_input();
    t_edge_rise();
    t_clear_race();
    t_edge_fall();
    t_level();
    t_raw_off();
    t_irq_off();
    t_route();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule